// File: doc/BRIEF.md
# SDRAM Deep Power-Down Sequencer

This block sits on the controller side of a low-power SDRAM. It takes the device into its deepest sleep state, where the array loses power, and later brings it back to a state where it accepts commands. A power manager raises `enter_req` to ask for sleep and `exit_req` to ask for wake-up. The block drives the chip-select, row-strobe, column-strobe, write-enable, clock-enable, address and bank pins of the SDRAM command bus while it owns them. Outside a sleep or wake-up sequence it drives NOP with clock enable high and reports `ready`.

Sleep is allowed only while `banks_idle` shows that no bank is open. Otherwise the request waits, and takes effect on the first cycle in which the banks are idle. The memory contents are lost during sleep, so waking up is a full re-initialisation. Clock enable goes high, and NOP is held for a timed settling period of 200 µs, counted in clocks. A precharge-all follows, then a counted burst of auto-refresh commands, then a mode register load and an extended mode register load. The values for both register loads come from input ports. Each command gap is timed by a parameterised counter. A sticky flag reports that memory contents are no longer valid.

Top module: `sdram_deep_sleep_seq`

## Requirements
- R1: After reset the block drives NOP (cs_n,ras_n,cas_n,we_n = 0,1,1,1) with cke=1, and shows ready=1, busy=0, asleep=0 and contents_lost=0.
- R2: While banks_idle=0, enter_req has no effect: the outputs stay as in R1 with ready=1.
- R3: On the first clock edge where enter_req=1, banks_idle=1 and ready=1 are all sampled, the next cycle drives the sleep command (0,1,1,0) with cke=0 for one cycle. After that the block drives NOP with cke=0 and asleep=1.
- R4: While asleep, cke stays 0 and enter_req has no effect. Only exit_req, sampled on a clock edge, starts the wake-up.
- R5: Wake-up starts with exactly WAKE_CYC cycles of NOP with cke=1, where WAKE_CYC = CLK_MHZ*WAKE_US.
- R6: Next comes one precharge command (0,0,1,0) with addr[AP_BIT]=1 (all banks), followed by exactly RP_CYC NOP cycles.
- R7: Next come N_REF auto-refresh commands (0,0,0,1), each followed by exactly RFC_CYC NOP cycles.
- R8: Next comes one register load (0,0,0,0) with ba=0 and addr=mode_val, followed by exactly MRD_CYC NOP cycles.
- R9: Next comes one register load (0,0,0,0) with ba=2 and addr=ext_mode_val, followed by exactly MRD_CYC NOP cycles. In the cycle after that, ready returns to 1.
- R10: busy is 1 during the sleep command cycle and throughout wake-up, and 0 otherwise. ready is 1 only when the block is neither busy nor asleep.
- R11: contents_lost becomes 1 in the cycle after the sleep command and stays 1 until reset.
- R12: During wake-up, enter_req, exit_req and banks_idle have no effect on the command sequence. While ready, exit_req has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| enter_req | input | 1 | Request to enter deep sleep (level) |
| exit_req | input | 1 | Request to wake up (level) |
| banks_idle | input | 1 | All SDRAM banks are precharged |
| mode_val | input | AW | Value loaded into the mode register |
| ext_mode_val | input | AW | Value loaded into the extended mode register |
| cs_n | output | 1 | SDRAM chip select, active low |
| ras_n | output | 1 | SDRAM row strobe, active low |
| cas_n | output | 1 | SDRAM column strobe, active low |
| we_n | output | 1 | SDRAM write enable, active low |
| cke | output | 1 | SDRAM clock enable |
| addr | output | AW | SDRAM address bus |
| ba | output | 2 | SDRAM bank address |
| busy | output | 1 | A sleep or wake-up sequence is running |
| ready | output | 1 | SDRAM usable for normal traffic |
| asleep | output | 1 | SDRAM held in deep sleep |
| contents_lost | output | 1 | Memory contents invalid since a sleep |

## Verification
A wrong state or counter value shows at the command pins within one cycle. The command pins are decoded directly from the state register, so a skipped state, an extra refresh, or a gap that is one cycle short or long moves a command to a different cycle. The bench compares every cycle of the wake-up against a timeline computed from the parameters, so any such shift is caught on the exact cycle where it appears. A timer that never expires leaves busy high and ready low, which the final-cycle check and the watchdog report.

// File: rtl/sds_pkg.sv
package sds_pkg;

    typedef enum logic [3:0] {
        ST_ACTIVE,
        ST_ENTER,
        ST_SLEEP,
        ST_WAKE,
        ST_PRE,
        ST_WAIT_RP,
        ST_REF,
        ST_WAIT_RFC,
        ST_MRS,
        ST_WAIT_MRD,
        ST_EMRS,
        ST_WAIT_EMRD
    } state_e;

    // Command bus: chip select, row strobe, column strobe, write enable
    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_t;

    localparam cmd_t CMD_NOP   = 4'b0111;
    localparam cmd_t CMD_SLEEP = 4'b0110;
    localparam cmd_t CMD_PRE   = 4'b0010;
    localparam cmd_t CMD_REF   = 4'b0001;
    localparam cmd_t CMD_LOAD  = 4'b0000;

    localparam logic [1:0] BA_MODE = 2'b00;
    localparam logic [1:0] BA_EXT  = 2'b10;

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic seq_running(state_e s);
        return (s != ST_ACTIVE) && (s != ST_SLEEP);
    endfunction

endpackage

// File: rtl/sds_timer.sv
module sds_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expire
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Loaded with N, the count reaches 1 in the Nth cycle after the load
    assign expire = (cnt == TW'(1));
endmodule

// File: rtl/sds_cmd_enc.sv
module sds_cmd_enc
    import sds_pkg::*;
#(
    parameter int AW     = 13,
    parameter int AP_BIT = 10
) (
    input  state_e        st,
    input  logic [AW-1:0] mode_val,
    input  logic [AW-1:0] ext_mode_val,
    output cmd_t          cmd,
    output logic          cke,
    output logic [AW-1:0] addr,
    output logic [1:0]    ba
);
    always_comb begin
        cmd  = CMD_NOP;
        cke  = 1'b1;
        addr = '0;
        ba   = 2'b00;
        unique case (st)
            ST_ENTER: begin
                cmd = CMD_SLEEP;
                cke = 1'b0;
            end
            ST_SLEEP: cke = 1'b0;
            ST_PRE: begin
                cmd          = CMD_PRE;
                addr[AP_BIT] = 1'b1;
            end
            ST_REF: cmd = CMD_REF;
            ST_MRS: begin
                cmd  = CMD_LOAD;
                addr = mode_val;
                ba   = BA_MODE;
            end
            ST_EMRS: begin
                cmd  = CMD_LOAD;
                addr = ext_mode_val;
                ba   = BA_EXT;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sdram_deep_sleep_seq.sv
module sdram_deep_sleep_seq
    import sds_pkg::*;
#(
    parameter int AW      = 13,
    parameter int AP_BIT  = 10,
    parameter int CLK_MHZ = 250,
    parameter int WAKE_US = 200,
    parameter int RP_CYC  = 3,
    parameter int RFC_CYC = 18,
    parameter int MRD_CYC = 2,
    parameter int N_REF   = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enter_req,
    input  logic          exit_req,
    input  logic          banks_idle,
    input  logic [AW-1:0] mode_val,
    input  logic [AW-1:0] ext_mode_val,
    output logic          cs_n,
    output logic          ras_n,
    output logic          cas_n,
    output logic          we_n,
    output logic          cke,
    output logic [AW-1:0] addr,
    output logic [1:0]    ba,
    output logic          busy,
    output logic          ready,
    output logic          asleep,
    output logic          contents_lost
);
    localparam int WAKE_CYC = CLK_MHZ * WAKE_US;
    localparam int MAX_GAP  = max2(max2(WAKE_CYC, RP_CYC), max2(RFC_CYC, MRD_CYC));
    localparam int TW       = $clog2(MAX_GAP + 1);
    localparam int RW       = $clog2(N_REF + 1);

    state_e        st, st_nxt;
    logic          t_load;
    logic [TW-1:0] t_val;
    logic          t_exp;
    logic [RW-1:0] ref_cnt;
    logic          lost_q;
    cmd_t          cmd;

    sds_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .expire   (t_exp)
    );

    sds_cmd_enc #(.AW(AW), .AP_BIT(AP_BIT)) u_enc (
        .st           (st),
        .mode_val     (mode_val),
        .ext_mode_val (ext_mode_val),
        .cmd          (cmd),
        .cke          (cke),
        .addr         (addr),
        .ba           (ba)
    );

    always_comb begin
        st_nxt = st;
        t_load = 1'b0;
        t_val  = '0;
        unique case (st)
            ST_ACTIVE:   if (enter_req && banks_idle) st_nxt = ST_ENTER;
            ST_ENTER:    st_nxt = ST_SLEEP;
            ST_SLEEP: begin
                if (exit_req) begin
                    st_nxt = ST_WAKE;
                    t_load = 1'b1;
                    t_val  = TW'(WAKE_CYC);
                end
            end
            ST_WAKE:     if (t_exp) st_nxt = ST_PRE;
            ST_PRE: begin
                st_nxt = ST_WAIT_RP;
                t_load = 1'b1;
                t_val  = TW'(RP_CYC);
            end
            ST_WAIT_RP:  if (t_exp) st_nxt = ST_REF;
            ST_REF: begin
                st_nxt = ST_WAIT_RFC;
                t_load = 1'b1;
                t_val  = TW'(RFC_CYC);
            end
            ST_WAIT_RFC: begin
                if (t_exp) st_nxt = (ref_cnt == RW'(N_REF)) ? ST_MRS : ST_REF;
            end
            ST_MRS: begin
                st_nxt = ST_WAIT_MRD;
                t_load = 1'b1;
                t_val  = TW'(MRD_CYC);
            end
            ST_WAIT_MRD: if (t_exp) st_nxt = ST_EMRS;
            ST_EMRS: begin
                st_nxt = ST_WAIT_EMRD;
                t_load = 1'b1;
                t_val  = TW'(MRD_CYC);
            end
            ST_WAIT_EMRD: if (t_exp) st_nxt = ST_ACTIVE;
            default:     st_nxt = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_ACTIVE;
            ref_cnt <= '0;
            lost_q  <= 1'b0;
        end else begin
            st <= st_nxt;
            if (st == ST_PRE) ref_cnt <= '0;
            else if (st == ST_REF) ref_cnt <= ref_cnt + 1'b1;
            if (st == ST_ENTER) lost_q <= 1'b1;
        end
    end

    assign cs_n          = cmd.cs_n;
    assign ras_n         = cmd.ras_n;
    assign cas_n         = cmd.cas_n;
    assign we_n          = cmd.we_n;
    assign busy          = seq_running(st);
    assign ready         = (st == ST_ACTIVE);
    assign asleep        = (st == ST_SLEEP);
    assign contents_lost = lost_q;
endmodule

// File: rtl/sds_checker.sv
module sds_checker (
    input logic clk,
    input logic rst,
    input logic enter_req,
    input logic banks_idle,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic cke,
    input logic busy,
    input logic ready,
    input logic asleep,
    input logic contents_lost
);
    logic [3:0] c;
    assign c = {cs_n, ras_n, cas_n, we_n};

    assert_sleep_cmd_cke_low_R3: assert property (@(posedge clk) disable iff (rst)
        (c == 4'b0110) |-> !cke);

    assert_sleep_cmd_needs_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (c == 4'b0110) |-> $past(ready && enter_req && banks_idle));

    assert_cke_low_asleep_R4: assert property (@(posedge clk) disable iff (rst)
        asleep |-> !cke);

    assert_cke_rises_from_sleep_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |-> $past(asleep));

    assert_ref_then_nop_R7: assert property (@(posedge clk) disable iff (rst)
        (c == 4'b0001) |=> (c == 4'b0111));

    assert_status_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        $countones({ready, busy, asleep}) == 1);

    assert_lost_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        contents_lost |=> contents_lost);
endmodule

bind sdram_deep_sleep_seq sds_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .enter_req     (enter_req),
    .banks_idle    (banks_idle),
    .cs_n          (cs_n),
    .ras_n         (ras_n),
    .cas_n         (cas_n),
    .we_n          (we_n),
    .cke           (cke),
    .busy          (busy),
    .ready         (ready),
    .asleep        (asleep),
    .contents_lost (contents_lost)
);

// File: tb/sdram_deep_sleep_seq_bench.sv
`timescale 1ns/1ps
module sdram_deep_sleep_seq_bench;
    localparam int AW = 13, AP_BIT = 10, CLK_MHZ = 250, WAKE_US = 1;
    localparam int RP = 3, RFC = 18, MRD = 2, NREF = 8;
    localparam int W   = CLK_MHZ * WAKE_US;
    localparam int T_REF0 = W + 1 + RP;
    localparam int T_MRS  = T_REF0 + NREF * (RFC + 1);
    localparam int T_EMRS = T_MRS + MRD + 1;
    localparam int T_RDY  = T_EMRS + MRD + 1;

    logic clk = 1'b0, rst = 1'b1;
    logic enter_req = 1'b0, exit_req = 1'b0, banks_idle = 1'b0;
    logic [AW-1:0] mode_val = '0, ext_mode_val = '0;
    logic cs_n, ras_n, cas_n, we_n, cke, busy, ready, asleep, contents_lost;
    logic [AW-1:0] addr;
    logic [1:0] ba;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sdram_deep_sleep_seq #(
        .AW(AW), .AP_BIT(AP_BIT), .CLK_MHZ(CLK_MHZ), .WAKE_US(WAKE_US),
        .RP_CYC(RP), .RFC_CYC(RFC), .MRD_CYC(MRD), .N_REF(NREF)
    ) u_sdram_deep_sleep_seq (
        .clk(clk), .rst(rst), .enter_req(enter_req), .exit_req(exit_req),
        .banks_idle(banks_idle), .mode_val(mode_val), .ext_mode_val(ext_mode_val),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke),
        .addr(addr), .ba(ba), .busy(busy), .ready(ready), .asleep(asleep),
        .contents_lost(contents_lost)
    );

    function automatic logic [3:0] cmd_now();
        return {cs_n, ras_n, cas_n, we_n};
    endfunction

    // Expected command at cycle t of a wake-up (t=0: first cycle after exit_req sampled)
    function automatic logic [3:0] exp_cmd(int t);
        if (t == W) return 4'b0010;
        if (t >= T_REF0 && t < T_MRS && ((t - T_REF0) % (RFC + 1)) == 0) return 4'b0001;
        if (t == T_MRS || t == T_EMRS) return 4'b0000;
        return 4'b0111;
    endfunction

    function automatic string req_of(int t);
        if (t < W) return "R5";
        if (t < T_REF0) return "R6";
        if (t < T_MRS) return "R7";
        if (t < T_EMRS) return "R8";
        return "R9";
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_idle_ready(string req);
        chk(cmd_now() == 4'b0111, req, "cmd", cmd_now(), 4'b0111);
        chk(cke == 1'b1, req, "cke", cke, 1);
        chk(ready && !busy && !asleep, req, "ready/busy/asleep",
            {ready, busy, asleep}, 3'b100);
    endtask

    task automatic go_to_sleep(int hold);
        // R2: enter_req while banks busy is held off; exit_req while ready ignored (R12)
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (i > 0) check_idle_ready("R2");
            enter_req  = 1'b1;
            banks_idle = 1'b0;
            exit_req   = 1'($urandom);
        end
        @(negedge clk);
        if (hold > 0) check_idle_ready("R12");
        enter_req  = 1'b1;
        banks_idle = 1'b1;
        exit_req   = 1'b0;
        @(negedge clk);
        chk(cmd_now() == 4'b0110, "R3", "sleep cmd", cmd_now(), 4'b0110);
        chk(cke == 1'b0, "R3", "cke at sleep cmd", cke, 0);
        chk(busy && !ready, "R10", "busy at sleep cmd", {busy, ready}, 2'b10);
        enter_req  = 1'b0;
        banks_idle = 1'($urandom);
        @(negedge clk);
        chk(asleep && !busy && !ready, "R3", "asleep", {asleep, busy, ready}, 3'b100);
        chk(contents_lost == 1'b1, "R11", "contents_lost", contents_lost, 1);
    endtask

    task automatic sleep_for(int n);
        for (int i = 0; i < n; i++) begin
            enter_req  = 1'($urandom);
            banks_idle = 1'($urandom);
            exit_req   = 1'b0;
            @(negedge clk);
            chk(cke == 1'b0 && cmd_now() == 4'b0111, "R4", "cke/cmd asleep",
                {cke, cmd_now()}, 5'b00111);
            chk(asleep == 1'b1, "R4", "asleep", asleep, 1);
        end
    endtask

    task automatic wake_up();
        logic [AW-1:0] mv, ev;
        mv = AW'($urandom);
        ev = AW'($urandom);
        mode_val     = mv;
        ext_mode_val = ev;
        exit_req     = 1'b1;
        enter_req    = 1'b0;
        for (int t = 0; t <= T_RDY; t++) begin
            @(negedge clk);
            if (t < T_RDY) begin
                chk(cmd_now() == exp_cmd(t), req_of(t), "cmd", cmd_now(), exp_cmd(t));
                chk(cke == 1'b1, req_of(t), "cke", cke, 1);
                chk(busy && !ready, "R10", "busy during wake", {busy, ready}, 2'b10);
                if (t == W)
                    chk(addr[AP_BIT] == 1'b1, "R6", "all-bank bit", addr[AP_BIT], 1);
                if (t == T_MRS) begin
                    chk(addr == mv, "R8", "mode addr", addr, mv);
                    chk(ba == 2'b00, "R8", "mode ba", ba, 0);
                end
                if (t == T_EMRS) begin
                    chk(addr == ev, "R9", "ext addr", addr, ev);
                    chk(ba == 2'b10, "R9", "ext ba", ba, 2);
                end
                // R12: noise on requests during the sequence
                exit_req   = 1'($urandom);
                enter_req  = 1'($urandom);
                banks_idle = 1'($urandom);
                if (t == T_RDY - 1) begin
                    enter_req = 1'b0;
                    exit_req  = 1'b0;
                end
            end else begin
                chk(ready == 1'b1, "R9", "ready after ext load", ready, 1);
                check_idle_ready("R10");
                chk(contents_lost == 1'b1, "R11", "contents_lost kept", contents_lost, 1);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_idle_ready("R1");
        chk(contents_lost == 1'b0, "R1", "contents_lost at reset", contents_lost, 0);
        // Directed: entry immediately with banks idle, minimal sleep
        go_to_sleep(0);
        sleep_for(1);
        wake_up();
        // Random rounds
        for (int r = 0; r < 5; r++) begin
            go_to_sleep(1 + int'($urandom % 6));
            sleep_for(1 + int'($urandom % 20));
            wake_up();
        end
        // R12: exit_req while ready leaves the block idle
        for (int i = 0; i < 5; i++) begin
            exit_req  = 1'b1;
            enter_req = 1'b0;
            @(negedge clk);
            check_idle_ready("R12");
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule